// File: doc/BRIEF.md
# Two-Player Paddle Game Engine

This block holds the complete state of a two-player paddle-and-ball game and turns it into colour, one pixel at a time, from the scan coordinates that an external display timing generator supplies. Each player has a single direction switch. On every frame tick, which arrives during vertical blanking, the block moves both paddles and the ball. The ball rebounds from the top and bottom walls and from the paddles. When the ball gets past a paddle it returns to the centre of the field and the other player gains a point.

Paddle-ball contact is not found by comparing coordinates. It is found by the renderer itself: the block notes any visible pixel that would be painted by both the paddle layer (red) and the ball layer (blue). That event is latched during the frame and acted on at the next frame tick. Once either score reaches nine, the game freezes until reset. Score display and video timing belong to neighbouring blocks.

Top module: `pong_core`

## Requirements
- R1: While `pix_vis` is 0 the colour outputs are all zero. A visible pixel whose x is below BORDER (10) or at least H_VIS-BORDER, or whose y is below BORDER or at least V_VIS-BORDER, is white (red, green and blue all 4'hF).
- R2: Inside the field, a pixel on a paddle has red 4'hF and a pixel on the ball has blue 4'hF. Green is 0, and a pixel on neither is black. A pixel on both has red 4'hF and blue 4'hF. The left paddle covers x from BORDER+PAD_GAP for PAD_W pixels. The right paddle ends at x H_VIS-BORDER-PAD_GAP. Each paddle spans PAD_H rows from its top y. The ball is a BALL by BALL square at its top-left corner.
- R3: On each frame tick a paddle moves PAD_STEP rows: up (y decreases) when its switch is 1, down when it is 0.
- R4: A paddle's top stays between BORDER and V_VIS-BORDER-PAD_H. A step that would leave this range stops at the limit.
- R5: On each frame tick the ball moves BALL_SPEED pixels along each axis. Moving up with y below BORDER+BALL_SPEED, it is placed at y=BORDER and turns down. Moving down with y above V_VIS-BORDER-BALL-BALL_SPEED, it is placed at the bottom limit and turns up.
- R6: A visible pixel covered by both a paddle and the ball is latched as a contact. At the next frame tick the ball's horizontal direction is reversed before the move, and the latch is cleared.
- R7: After a reversal, further contacts are ignored until a frame tick arrives with no contact latched in the frame before it.
- R8: A ball moving left with x below BORDER+BALL_SPEED, or moving right with x above H_VIS-BORDER-BALL-BALL_SPEED, returns to the centre at that tick and keeps its directions. The player on the opposite side (right or left respectively) gains one point.
- R9: Scores stay in 0..9. Once either score is 9, frame ticks no longer move the paddles or the ball and no longer change the scores.
- R10: Reset (synchronous, active low) puts both paddle tops at (V_VIS-PAD_H)/2 and the ball at ((H_VIS-BALL)/2, (V_VIS-BALL)/2), moving right and down. It clears both scores and the colour outputs.
- R11: The colour for the pixel presented at one clock edge appears on the outputs after that edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | CW | Current scan column |
| pix_y | input | CW | Current scan row |
| pix_vis | input | 1 | High when the scan position is in the visible area |
| frame_tick | input | 1 | One-cycle pulse in vertical blanking that advances the game |
| sw_left | input | 1 | Left player switch, 1 = up |
| sw_right | input | 1 | Right player switch, 1 = up |
| red | output | 4 | Red intensity |
| green | output | 4 | Green intensity |
| blue | output | 4 | Blue intensity |
| score_l | output | 4 | Left player score, 0..9 |
| score_r | output | 4 | Right player score, 0..9 |

## Verification
Several properties are checked on every cycle: the scores stay in range and rise only by one and only at a frame tick; the paddles stay inside their limits; positions change only on a tick; everything freezes once a score reaches nine; and blanked pixels give black one cycle later. Other behaviours are visible only as the outcome of a played game, and only the bench's scenarios can show them: a bounce reversing the ball exactly once per contact, the re-arm after the ball leaves the paddle, serve after a miss, and the exact ball path off the walls. The bench acts as the scanner, predicts every probed colour and both scores from its own game model, and plays to nine points with one paddle tracking the ball in turn.

// File: rtl/pong_pkg.sv
// Shared types for the paddle game engine.
// Assumes: colour channels are 4 bits, scores are single decimal digits.
package pong_pkg;
    localparam int SCORE_W = 4;
    localparam logic [SCORE_W-1:0] SCORE_LAST = 4'd9;

    typedef logic [SCORE_W-1:0] score_t;

    // Direction of travel along one axis: NEG = towards smaller coordinates
    typedef enum logic {DIR_NEG = 1'b0, DIR_POS = 1'b1} dir_t;

    typedef struct packed {
        logic [3:0] r;
        logic [3:0] g;
        logic [3:0] b;
    } rgb_t;
endpackage

// File: rtl/pong_paddle.sv
// One paddle: vertical position stepped once per enabled frame tick.
// Assumes: step_en is a single-cycle pulse; limits leave room for one step.
module pong_paddle #(
    parameter int CW     = 11,
    parameter int V_VIS  = 480,
    parameter int BORDER = 10,
    parameter int PAD_H  = 48,
    parameter int STEP   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          sw_up,
    output logic [CW-1:0] pos_y
);
    localparam logic [CW-1:0] Y_MIN  = CW'(BORDER);
    localparam logic [CW-1:0] Y_MAX  = CW'(V_VIS - BORDER - PAD_H);
    localparam logic [CW-1:0] Y_HOME = CW'((V_VIS - PAD_H) / 2);
    localparam logic [CW-1:0] STEP_C = CW'(STEP);

    // Move one step per tick, stopping at the field limits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_y <= Y_HOME;
        end else if (step_en) begin
            if (sw_up) begin
                pos_y <= (pos_y < Y_MIN + STEP_C) ? Y_MIN : pos_y - STEP_C;
            end else begin
                pos_y <= (pos_y > Y_MAX - STEP_C) ? Y_MAX : pos_y + STEP_C;
            end
        end
    end
endmodule

// File: rtl/pong_ball.sv
// Ball motion: wall bounces, paddle reversal with re-arm, miss detection.
// Assumes: hit_seen is the contact latch for the frame just scanned;
// miss pulses are valid only in the cycle of step_en.
module pong_ball
    import pong_pkg::*;
#(
    parameter int CW     = 11,
    parameter int H_VIS  = 640,
    parameter int V_VIS  = 480,
    parameter int BORDER = 10,
    parameter int BALL   = 8,
    parameter int SPEED  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          hit_seen,
    output logic [CW-1:0] pos_x,
    output logic [CW-1:0] pos_y,
    output logic          miss_lo,
    output logic          miss_hi
);
    localparam logic [CW-1:0] X_MIN  = CW'(BORDER);
    localparam logic [CW-1:0] X_MAX  = CW'(H_VIS - BORDER - BALL);
    localparam logic [CW-1:0] Y_MIN  = CW'(BORDER);
    localparam logic [CW-1:0] Y_MAX  = CW'(V_VIS - BORDER - BALL);
    localparam logic [CW-1:0] X_HOME = CW'((H_VIS - BALL) / 2);
    localparam logic [CW-1:0] Y_HOME = CW'((V_VIS - BALL) / 2);
    localparam logic [CW-1:0] SPD    = CW'(SPEED);

    dir_t          dx, dy, dx_n, dy_n;
    logic          armed, armed_n;
    logic [CW-1:0] x_n, y_n;

    // Next-state: paddle reversal first, then miss test, then move
    always_comb begin
        dx_n    = dx;
        dy_n    = dy;
        armed_n = armed;
        x_n     = pos_x;
        y_n     = pos_y;
        if (hit_seen) begin
            if (armed) begin
                dx_n    = (dx == DIR_POS) ? DIR_NEG : DIR_POS;
                armed_n = 1'b0;
            end
        end else begin
            armed_n = 1'b1;
        end
        miss_lo = step_en && (dx_n == DIR_NEG) && (pos_x < X_MIN + SPD);
        miss_hi = step_en && (dx_n == DIR_POS) && (pos_x > X_MAX - SPD);
        if (miss_lo || miss_hi) begin
            x_n = X_HOME;
            y_n = Y_HOME;
        end else begin
            x_n = (dx_n == DIR_POS) ? pos_x + SPD : pos_x - SPD;
            if (dy == DIR_NEG) begin
                if (pos_y < Y_MIN + SPD) begin
                    y_n  = Y_MIN;
                    dy_n = DIR_POS;
                end else begin
                    y_n = pos_y - SPD;
                end
            end else begin
                if (pos_y > Y_MAX - SPD) begin
                    y_n  = Y_MAX;
                    dy_n = DIR_NEG;
                end else begin
                    y_n = pos_y + SPD;
                end
            end
        end
    end

    // Commit motion state once per enabled tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x <= X_HOME;
            pos_y <= Y_HOME;
            dx    <= DIR_POS;
            dy    <= DIR_POS;
            armed <= 1'b1;
        end else if (step_en) begin
            pos_x <= x_n;
            pos_y <= y_n;
            dx    <= dx_n;
            dy    <= dy_n;
            armed <= armed_n;
        end
    end
endmodule

// File: rtl/pong_score.sv
// One player's score digit, saturating at the last value.
// Assumes: inc is a single-cycle pulse.
module pong_score
    import pong_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   inc,
    output score_t value
);
    // Count points up to the final value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (inc && value != SCORE_LAST) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/pong_render.sv
// Pixel renderer: layer membership, registered colour, contact flag.
// Assumes: positions are stable while the visible area is scanned.
module pong_render
    import pong_pkg::*;
#(
    parameter int CW      = 11,
    parameter int H_VIS   = 640,
    parameter int V_VIS   = 480,
    parameter int BORDER  = 10,
    parameter int PAD_GAP = 10,
    parameter int PAD_W   = 8,
    parameter int PAD_H   = 48,
    parameter int BALL    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] pix_y,
    input  logic          pix_vis,
    input  logic [CW-1:0] pad_l,
    input  logic [CW-1:0] pad_r,
    input  logic [CW-1:0] ball_x,
    input  logic [CW-1:0] ball_y,
    output rgb_t          colour,
    output logic          overlap
);
    localparam logic [CW-1:0] B_LO  = CW'(BORDER);
    localparam logic [CW-1:0] BX_HI = CW'(H_VIS - BORDER);
    localparam logic [CW-1:0] BY_HI = CW'(V_VIS - BORDER);
    localparam logic [CW-1:0] LX0   = CW'(BORDER + PAD_GAP);
    localparam logic [CW-1:0] RX0   = CW'(H_VIS - BORDER - PAD_GAP - PAD_W);
    localparam logic [CW-1:0] PW_C  = CW'(PAD_W);
    localparam logic [CW-1:0] PH_C  = CW'(PAD_H);
    localparam logic [CW-1:0] BL_C  = CW'(BALL);

    logic on_border, on_pad, on_ball;

    // Decide which layers cover the current pixel
    always_comb begin
        on_border = (pix_x < B_LO) || (pix_x >= BX_HI) ||
                    (pix_y < B_LO) || (pix_y >= BY_HI);
        on_pad    = ((pix_x >= LX0) && (pix_x < LX0 + PW_C) &&
                     (pix_y >= pad_l) && (pix_y < pad_l + PH_C)) ||
                    ((pix_x >= RX0) && (pix_x < RX0 + PW_C) &&
                     (pix_y >= pad_r) && (pix_y < pad_r + PH_C));
        on_ball   = (pix_x >= ball_x) && (pix_x < ball_x + BL_C) &&
                    (pix_y >= ball_y) && (pix_y < ball_y + BL_C);
        overlap   = pix_vis && on_pad && on_ball;
    end

    // Register the colour for this pixel
    always_ff @(posedge clk) begin
        if (!rst_n || !pix_vis) begin
            colour <= '0;
        end else if (on_border) begin
            colour <= '{r: 4'hF, g: 4'hF, b: 4'hF};
        end else begin
            colour <= '{r: {4{on_pad}}, g: 4'h0, b: {4{on_ball}}};
        end
    end
endmodule

// File: rtl/pong_core.sv
// Paddle game engine top: two paddles, ball, two scores, renderer.
// Assumes: frame_tick pulses for one cycle during blanking (pix_vis low),
// and pix_x/pix_y come from an external timing generator.
module pong_core
    import pong_pkg::*;
#(
    parameter int CW         = 11,
    parameter int H_VIS      = 640,
    parameter int V_VIS      = 480,
    parameter int BORDER     = 10,
    parameter int PAD_GAP    = 10,
    parameter int PAD_W      = 8,
    parameter int PAD_H      = 48,
    parameter int PAD_STEP   = 4,
    parameter int BALL       = 8,
    parameter int BALL_SPEED = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] pix_y,
    input  logic          pix_vis,
    input  logic          frame_tick,
    input  logic          sw_left,
    input  logic          sw_right,
    output logic [3:0]    red,
    output logic [3:0]    green,
    output logic [3:0]    blue,
    output logic [3:0]    score_l,
    output logic [3:0]    score_r
);
    localparam int NPLAYER = 2;

    logic [CW-1:0] pad_y [NPLAYER];
    score_t        score [NPLAYER];
    logic [CW-1:0] pad_y_l, pad_y_r, ball_x, ball_y;
    logic          game_over, step_en, overlap, hit_seen, miss_lo, miss_hi;
    rgb_t          colour;

    assign game_over = (score[0] == SCORE_LAST) || (score[1] == SCORE_LAST);
    assign step_en   = frame_tick && !game_over;

    // Player 0 is on the left, player 1 on the right
    for (genvar p = 0; p < NPLAYER; p++) begin : g_player
        pong_paddle #(
            .CW(CW), .V_VIS(V_VIS), .BORDER(BORDER), .PAD_H(PAD_H), .STEP(PAD_STEP)
        ) u_pad (
            .clk(clk), .rst_n(rst_n), .step_en(step_en),
            .sw_up((p == 0) ? sw_left : sw_right),
            .pos_y(pad_y[p])
        );
        pong_score u_score (
            .clk(clk), .rst_n(rst_n),
            .inc((p == 0) ? miss_hi : miss_lo),
            .value(score[p])
        );
    end

    assign pad_y_l = pad_y[0];
    assign pad_y_r = pad_y[1];

    pong_ball #(
        .CW(CW), .H_VIS(H_VIS), .V_VIS(V_VIS), .BORDER(BORDER),
        .BALL(BALL), .SPEED(BALL_SPEED)
    ) u_ball (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .hit_seen(hit_seen),
        .pos_x(ball_x), .pos_y(ball_y), .miss_lo(miss_lo), .miss_hi(miss_hi)
    );

    pong_render #(
        .CW(CW), .H_VIS(H_VIS), .V_VIS(V_VIS), .BORDER(BORDER), .PAD_GAP(PAD_GAP),
        .PAD_W(PAD_W), .PAD_H(PAD_H), .BALL(BALL)
    ) u_render (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .pix_vis(pix_vis),
        .pad_l(pad_y_l), .pad_r(pad_y_r), .ball_x(ball_x), .ball_y(ball_y),
        .colour(colour), .overlap(overlap)
    );

    // Hold any paddle-ball contact of the frame until the next tick clears it
    always_ff @(posedge clk) begin
        if (!rst_n || frame_tick) begin
            hit_seen <= 1'b0;
        end else if (overlap) begin
            hit_seen <= 1'b1;
        end
    end

    assign red     = colour.r;
    assign green   = colour.g;
    assign blue    = colour.b;
    assign score_l = score[0];
    assign score_r = score[1];
endmodule

// File: rtl/pong_core_chk.sv
// Property checker for pong_core, attached by bind below.
// Assumes: reset is held for at least two clock cycles at start-up.
module pong_core_chk #(
    parameter int CW     = 11,
    parameter int V_VIS  = 480,
    parameter int BORDER = 10,
    parameter int PAD_H  = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_vis,
    input logic          frame_tick,
    input logic [3:0]    red,
    input logic [3:0]    green,
    input logic [3:0]    blue,
    input logic [3:0]    score_l,
    input logic [3:0]    score_r,
    input logic [CW-1:0] pad_l,
    input logic [CW-1:0] pad_r,
    input logic [CW-1:0] ball_x,
    input logic [CW-1:0] ball_y
);
    localparam logic [CW-1:0] P_MIN = CW'(BORDER);
    localparam logic [CW-1:0] P_MAX = CW'(V_VIS - BORDER - PAD_H);

    a_r1_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vis |=> (red == 4'h0 && green == 4'h0 && blue == 4'h0));

    a_r4_paddle_range: assert property (@(posedge clk) disable iff (!rst_n)
        pad_l >= P_MIN && pad_l <= P_MAX && pad_r >= P_MIN && pad_r <= P_MAX);

    a_r5_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(ball_x) && $stable(ball_y) &&
                         $stable(pad_l) && $stable(pad_r)));

    a_r8_score_step_l: assert property (@(posedge clk) disable iff (!rst_n)
        (score_l != $past(score_l)) |-> (score_l == $past(score_l) + 4'd1 && $past(frame_tick)));

    a_r8_score_step_r: assert property (@(posedge clk) disable iff (!rst_n)
        (score_r != $past(score_r)) |-> (score_r == $past(score_r) + 4'd1 && $past(frame_tick)));

    a_r9_score_range: assert property (@(posedge clk) disable iff (!rst_n)
        score_l <= 4'd9 && score_r <= 4'd9);

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (score_l == 4'd9 || score_r == 4'd9) |=>
            ($stable(score_l) && $stable(score_r) && $stable(ball_x) &&
             $stable(ball_y) && $stable(pad_l) && $stable(pad_r)));
endmodule

bind pong_core pong_core_chk #(
    .CW(CW), .V_VIS(V_VIS), .BORDER(BORDER), .PAD_H(PAD_H)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_vis(pix_vis), .frame_tick(frame_tick),
    .red(red), .green(green), .blue(blue), .score_l(score_l), .score_r(score_r),
    .pad_l(pad_y_l), .pad_r(pad_y_r), .ball_x(ball_x), .ball_y(ball_y)
);

// File: tb/sim_pong_core.sv
// Bench for pong_core: acts as the scanner, predicts colours and scores.
module sim_pong_core;
    localparam int H = 640, V = 480, B = 10, GAP = 10, PW = 8, PH = 48;
    localparam int PS = 4, BS = 8, SP = 2;
    localparam int LX = B + GAP, RX = H - B - GAP - PW;
    localparam int HX = (H - BS) / 2, HY = (V - BS) / 2, HP = (V - PH) / 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [10:0] pix_x = '0, pix_y = '0;
    logic        pix_vis = 1'b0, frame_tick = 1'b0, sw_left = 1'b0, sw_right = 1'b0;
    logic [3:0]  red, green, blue, score_l, score_r;

    always #10 clk = ~clk;

    pong_core u0 (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .pix_vis(pix_vis),
        .frame_tick(frame_tick), .sw_left(sw_left), .sw_right(sw_right),
        .red(red), .green(green), .blue(blue), .score_l(score_l), .score_r(score_r)
    );

    int checks = 0, errors = 0;
    int mbx, mby, mdx, mdy, mpl, mpr, marm, msl, msr, mhit;

    function automatic bit in_span(int p, int lo, int len);
        return p >= lo && p < lo + len;
    endfunction
    function automatic bit m_pad(int x, int y);
        return (in_span(x, LX, PW) && in_span(y, mpl, PH)) ||
               (in_span(x, RX, PW) && in_span(y, mpr, PH));
    endfunction
    function automatic bit m_ball(int x, int y);
        return in_span(x, mbx, BS) && in_span(y, mby, BS);
    endfunction
    // Expected colour {r,g,b} from R1/R2
    function automatic int m_rgb(int x, int y, bit vis);
        if (!vis) return 0;
        if (x < B || x >= H - B || y < B || y >= V - B) return 'hFFF;
        return (m_pad(x, y) ? 'hF00 : 0) | (m_ball(x, y) ? 'h00F : 0);
    endfunction
    function automatic int pad_next(int p, bit up);
        if (up) return (p < B + PS) ? B : p - PS;
        return (p + PS > V - B - PH) ? V - B - PH : p + PS;
    endfunction
    function automatic bit over();
        return msl == 9 || msr == 9;
    endfunction

    task automatic model_reset();
        mbx = HX; mby = HY; mdx = 1; mdy = 1; mpl = HP; mpr = HP;
        marm = 1; msl = 0; msr = 0; mhit = 0;
    endtask

    // Game model: R3..R9 applied at one tick
    task automatic model_tick(bit sl, bit sr);
        int ndx;
        if (over()) begin
            mhit = 0;
            return;
        end
        mpl = pad_next(mpl, sl);
        mpr = pad_next(mpr, sr);
        ndx = mdx;
        if (mhit != 0) begin
            if (marm != 0) begin ndx = 1 - mdx; marm = 0; end
        end else marm = 1;
        if (ndx == 0 && mbx < B + SP) begin
            mbx = HX; mby = HY; msr++;
        end else if (ndx == 1 && mbx > H - B - BS - SP) begin
            mbx = HX; mby = HY; msl++;
        end else begin
            mbx += (ndx == 1) ? SP : -SP;
            if (mdy == 0) begin
                if (mby < B + SP) begin mby = B; mdy = 1; end
                else mby -= SP;
            end else begin
                if (mby > V - B - BS - SP) begin mby = V - B - BS; mdy = 0; end
                else mby += SP;
            end
        end
        mdx = ndx;
        mhit = 0;
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %03h expected %03h", tag, act, exp);
        end
    endtask

    // Present one pixel at a negedge; colour is read one edge later (R11)
    task automatic probe(int x, int y, bit vis, string tag);
        int exp;
        pix_x = 11'(x);
        pix_y = 11'(y);
        pix_vis = vis;
        exp = m_rgb(x, y, vis);
        if (vis && m_pad(x, y) && m_ball(x, y)) mhit = 1;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R11"}, int'({red, green, blue}), exp);
    endtask

    task automatic tick(bit sl, bit sr);
        pix_vis = 1'b0;
        sw_left = sl;
        sw_right = sr;
        frame_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_tick = 1'b0;
        model_tick(sl, sr);
    endtask

    // One frame: tick, then scan the pixels that reveal the state
    task automatic frame(bit sl, bit sr);
        tick(sl, sr);
        check("R8 R9 score_l", int'(score_l), msl);
        check("R8 R9 score_r", int'(score_r), msr);
        probe(mbx, mby, 1'b1, "R5 R6 R7 ball");
        probe(mbx - 1, mby + BS - 1, 1'b1, "R5 R6 R7 ball edge");
        probe(LX, mpl, 1'b1, "R3 R4 left top");
        probe(LX + PW - 1, mpl - 1, 1'b1, "R3 R4 left above");
        probe(RX, mpr + PH - 1, 1'b1, "R3 R4 right bottom");
        probe(RX, mpr + PH, 1'b1, "R3 R4 right below");
        probe($urandom_range(0, H - 1), $urandom_range(0, V - 1),
              $urandom_range(0, 3) != 0, "R1 R2 random");
        if (mbx < LX + PW && mbx + BS > LX && mby < mpl + PH && mby + BS > mpl)
            probe((mbx > LX) ? mbx : LX, (mby > mpl) ? mby : mpl, 1'b1, "R2 R6 contact");
        if (mbx < RX + PW && mbx + BS > RX && mby < mpr + PH && mby + BS > mpr)
            probe((mbx > RX) ? mbx : RX, (mby > mpr) ? mby : mpr, 1'b1, "R2 R6 contact");
    endtask

    function automatic bit follow(int p);
        if ($urandom_range(0, 7) == 0) return 1'($urandom_range(0, 1));
        return (p + PH / 2) > (mby + BS / 2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0, s1;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R10 reset state
        check("R10 score_l", int'(score_l), 0);
        check("R10 score_r", int'(score_r), 0);
        check("R10 colour", int'({red, green, blue}), 0);
        probe(HX, HY, 1'b1, "R10 ball home");
        probe(LX, HP, 1'b1, "R10 paddle home");
        probe(RX, HP - 1, 1'b1, "R10 paddle home");
        // R1 border and blanking corners
        probe(0, 0, 1'b1, "R1 corner");
        probe(H - 1, V - 1, 1'b1, "R1 corner");
        probe(B - 1, 100, 1'b1, "R1 border edge");
        probe(B, B, 1'b1, "R1 field edge");
        probe(H - B, 200, 1'b1, "R1 border edge");
        probe(HX, HY, 1'b0, "R1 blanked ball");
        // R3/R4 clamp: left held up, right held down
        for (int f = 0; f < 70; f++) frame(1'b1, 1'b0);
        // Play: one side tracks the ball, the other moves at random
        for (int f = 0; f < 12000 && !over(); f++) begin
            if (((f / 400) % 2) == 0) frame(1'($urandom_range(0, 1)), follow(mpr));
            else frame(follow(mpl), 1'($urandom_range(0, 1)));
        end
        check("R9 game ended", int'(over()), 1);
        s0 = msl;
        s1 = msr;
        // R9 frozen game
        for (int f = 0; f < 20; f++) frame(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        check("R9 frozen score_l", int'(score_l), s0);
        check("R9 frozen score_r", int'(score_r), s1);
        // R10 reset from a finished game
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R10 rescore_l", int'(score_l), 0);
        check("R10 rescore_r", int'(score_r), 0);
        for (int f = 0; f < 10; f++) frame(1'b0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule